// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block keeps the protection state of a small serial-memory status register and answers, every cycle, whether a status write or an array write at a given address is allowed. It holds a two-bit block-protection level, a hardware-protect enable bit, a volatile write-enable latch and a busy flag for the internal write cycle. The command decoder in front of it supplies one-cycle strobes for write-enable, write-disable and status-write (with a data byte), an array-write commit strobe with its candidate address, and a pulse at the end of each internal write cycle.

Array protection grows downward from the top of the address space: none, the upper quarter, the upper half, or everything. A hardware pin gate blocks status writes only when the enable bit is set and the pin is low, and in that state the enable bit cannot be cleared. While an internal write cycle runs, every command other than a status read is ignored. The protection bits are plain registers with a reset value; real nonvolatile storage, serial shifting and the array are outside this block.

Top module: `sr_wp_ctrl`

## Requirements
- R1: After reset `status_o` reads 0x00 and both `arr_wr_ok_o` and `sr_wr_ok_o` are 0.
- R2: A `wren_i` strobe sets the write-enable latch (status bit 1) from the next cycle; a `wrdi_i` strobe clears it; when both arrive in the same cycle the latch ends up clear.
- R3: The protection level held in status bits 3:2 maps as follows: 00 protects nothing, 01 protects addresses with `addr_i[14:13]` = 11 (0x6000 to 0x7FFF), 10 protects addresses with `addr_i[14]` = 1 (0x4000 to 0x7FFF), 11 protects the whole array; `arr_wr_ok_o` is 0 for any protected address.
- R4: Hardware protection is active exactly when `wp_i` is 0 and the enable bit (status bit 7) is 1; while active `sr_wr_ok_o` is 0, yet array writes to unprotected addresses stay allowed.
- R5: With the write-enable latch clear, `arr_wr_ok_o` and `sr_wr_ok_o` are both 0 whatever `wp_i` and the enable bit are.
- R6: A `wrsr_i` strobe while `sr_wr_ok_o` is 1 loads status bits 3:2 from `sr_data_i[3:2]` and bit 7 from `sr_data_i[7]` and sets busy; a refused `wrsr_i` changes no status bit.
- R7: While `wp_i` is 0 and the enable bit is 1, the enable bit stays 1.
- R8: Busy (status bit 0) is set by an accepted status write or by an `arr_wr_i` commit while `arr_wr_ok_o` is 1; while busy both permission flags are 0 and `wren_i`, `wrdi_i` and `wrsr_i` have no effect.
- R9: A `wc_done_i` pulse while busy clears both busy and the write-enable latch from the next cycle.
- R10: An `arr_wr_i` commit while `arr_wr_ok_o` is 0 is ignored: busy stays 0 and the write-enable latch keeps its value.
- R11: Status bits 6:4 always read 0, and `sr_data_i` bits 6:4, 1 and 0 never reach the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wp_i | input | 1 | Write-protect pin level, 0 = asserted |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| wrsr_i | input | 1 | Status-write command strobe |
| sr_data_i | input | 8 | Data byte for status write |
| addr_i | input | 15 | Candidate array write address |
| arr_wr_i | input | 1 | Array write commit strobe |
| wc_done_i | input | 1 | End of internal write cycle pulse |
| status_o | output | 8 | Status byte for reads |
| arr_wr_ok_o | output | 1 | Array write at `addr_i` allowed |
| sr_wr_ok_o | output | 1 | Status write allowed |

## Verification
The bench builds the block with its default 15-bit address and zero reset values for the protection bits, so the level boundaries sit at 0x4000 and 0x6000 and every boundary address, including 0x0000 and 0x7FFF, is driven directly. With zero reset values each scenario starts from an unprotected array, which puts the pin-gate lock, refused commands and the busy window within reach of a few strobes.

// File: rtl/sr_wp_pkg.sv
package sr_wp_pkg;
  localparam int unsigned SR_W       = 8;
  localparam int unsigned SR_BUSY    = 0;
  localparam int unsigned SR_WEL     = 1;
  localparam int unsigned SR_LVL_LO  = 2;
  localparam int unsigned SR_LVL_HI  = 3;
  localparam int unsigned SR_HWEN    = 7;

  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_lvl_e;
endpackage

// File: rtl/sr_prot_map.sv
module sr_prot_map
  import sr_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  prot_lvl_e           lvl_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                prot_o
);
  localparam int unsigned TOP = ADDR_W - 1;

  always_comb begin
    unique case (lvl_i)
      PROT_NONE: prot_o = 1'b0;
      PROT_QTR:  prot_o = addr_i[TOP] & addr_i[TOP-1];
      PROT_HALF: prot_o = addr_i[TOP];
      PROT_ALL:  prot_o = 1'b1;
      default:   prot_o = 1'b1;
    endcase
  end

  always_comb begin
    if (lvl_i == PROT_NONE) AST_NONE_OPEN: assert (!prot_o); // R3
    if (!addr_i[TOP])       AST_LOW_HALF:  assert (!prot_o || lvl_i == PROT_ALL); // R3
  end
endmodule

// File: rtl/sr_nv_bits.sv
module sr_nv_bits
  import sr_wp_pkg::*;
#(
  parameter logic [1:0] RST_LVL  = 2'b00,
  parameter logic       RST_HWEN = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [SR_W-1:0] data_i,
  output prot_lvl_e       lvl_o,
  output logic            hwen_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o  <= prot_lvl_e'(RST_LVL);
      hwen_o <= RST_HWEN;
    end else if (load_i) begin
      lvl_o  <= prot_lvl_e'(data_i[SR_LVL_HI:SR_LVL_LO]);
      hwen_o <= data_i[SR_HWEN];
    end
  end

  AST_HOLD_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(lvl_o) && $stable(hwen_o)); // R6
endmodule

// File: rtl/sr_wel_busy.sv
module sr_wel_busy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wren_i,
  input  logic wrdi_i,
  input  logic start_i,
  input  logic done_i,
  output logic wel_o,
  output logic busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_o  <= 1'b0;
      busy_o <= 1'b0;
    end else if (busy_o) begin
      if (done_i) begin
        busy_o <= 1'b0;
        wel_o  <= 1'b0;
      end
    end else begin
      if (start_i)     busy_o <= 1'b1;
      if (wrdi_i)      wel_o  <= 1'b0;
      else if (wren_i) wel_o  <= 1'b1;
    end
  end

  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && done_i |=> !busy_o && !wel_o); // R9
  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_i |=> busy_o && $stable(wel_o)); // R8
  AST_WRDI_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && wrdi_i |=> !wel_o); // R2
endmodule

// File: rtl/sr_wp_ctrl.sv
module sr_wp_ctrl
  import sr_wp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 15,
  parameter logic [1:0]  RST_LVL  = 2'b00,
  parameter logic        RST_HWEN = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        sr_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              arr_wr_i,
  input  logic              wc_done_i,
  output logic [7:0]        status_o,
  output logic              arr_wr_ok_o,
  output logic              sr_wr_ok_o
);
  prot_lvl_e lvl;
  logic      hwen, wel, busy, addr_prot, hw_prot, sr_load, wc_start;

  sr_prot_map #(.ADDR_W(ADDR_W)) u_map (
    .lvl_i  (lvl),
    .addr_i (addr_i),
    .prot_o (addr_prot)
  );

  sr_nv_bits #(.RST_LVL(RST_LVL), .RST_HWEN(RST_HWEN)) u_bits (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sr_load),
    .data_i (sr_data_i),
    .lvl_o  (lvl),
    .hwen_o (hwen)
  );

  sr_wel_busy u_wel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wren_i  (wren_i),
    .wrdi_i  (wrdi_i),
    .start_i (wc_start),
    .done_i  (wc_done_i),
    .wel_o   (wel),
    .busy_o  (busy)
  );

  // pin gate only counts when the enable bit is set
  assign hw_prot     = hwen & ~wp_i;
  assign sr_wr_ok_o  = wel & ~busy & ~hw_prot;
  assign arr_wr_ok_o = wel & ~busy & ~addr_prot;
  assign sr_load     = wrsr_i & sr_wr_ok_o;
  assign wc_start    = sr_load | (arr_wr_i & arr_wr_ok_o);

  always_comb begin
    status_o            = '0;
    status_o[SR_BUSY]   = busy;
    status_o[SR_WEL]    = wel;
    status_o[SR_LVL_HI:SR_LVL_LO] = lvl;
    status_o[SR_HWEN]   = hwen;
  end

  AST_HWEN_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hwen && !wp_i |=> hwen); // R7
  AST_NO_WEL_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[SR_WEL] |-> !arr_wr_ok_o && !sr_wr_ok_o); // R5
  AST_PIN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_i && status_o[SR_HWEN] |-> !sr_wr_ok_o); // R4
  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[SR_BUSY] |-> !arr_wr_ok_o && !sr_wr_ok_o); // R8
  AST_REFUSED_ARR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_wr_i && !arr_wr_ok_o && !busy && !wrsr_i |=> !busy); // R10
  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6:4] == 3'b000); // R11
endmodule

// File: tb/tb_sr_wp_ctrl.sv
module tb_sr_wp_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wp_i = 1'b1;
  logic        wren_i = 1'b0, wrdi_i = 1'b0, wrsr_i = 1'b0;
  logic [7:0]  sr_data_i = '0;
  logic [14:0] addr_i = '0;
  logic        arr_wr_i = 1'b0, wc_done_i = 1'b0;
  logic [7:0]  status_o;
  logic        arr_wr_ok_o, sr_wr_ok_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  sr_wp_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wp_i(wp_i), .wren_i(wren_i), .wrdi_i(wrdi_i),
    .wrsr_i(wrsr_i), .sr_data_i(sr_data_i), .addr_i(addr_i), .arr_wr_i(arr_wr_i),
    .wc_done_i(wc_done_i), .status_o(status_o), .arr_wr_ok_o(arr_wr_ok_o),
    .sr_wr_ok_o(sr_wr_ok_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle strobe helpers: drive at negedge, release at next negedge
  task automatic step();
    @(negedge clk_i);
    wren_i = 0; wrdi_i = 0; wrsr_i = 0; arr_wr_i = 0; wc_done_i = 0;
    #1;
  endtask
  task automatic do_wren(); @(negedge clk_i); wren_i = 1; step(); endtask
  task automatic do_wrdi(); @(negedge clk_i); wrdi_i = 1; step(); endtask
  task automatic do_done(); @(negedge clk_i); wc_done_i = 1; step(); endtask
  task automatic do_wrsr(input logic [7:0] d);
    @(negedge clk_i); sr_data_i = d; wrsr_i = 1; step();
  endtask
  task automatic do_arr(input logic [14:0] a);
    @(negedge clk_i); addr_i = a; arr_wr_i = 1; step();
  endtask
  task automatic set_sr(input logic [7:0] d);
    wp_i = 1; do_wren(); do_wrsr(d); do_done();
  endtask

  function automatic logic exp_prot(input logic [1:0] lvl, input logic [14:0] a);
    case (lvl)
      2'b00: return 1'b0;
      2'b01: return a >= 15'h6000;
      2'b10: return a >= 15'h4000;
      default: return 1'b1;
    endcase
  endfunction

  task automatic t_reset();
    #1;
    check("R1 status", status_o, 8'h00);
    check("R1 arr_ok", {7'd0, arr_wr_ok_o}, 8'h00);
    check("R1 sr_ok", {7'd0, sr_wr_ok_o}, 8'h00);
  endtask

  task automatic t_wel();
    do_wren();
    check("R2 wren sets", status_o, 8'h02);
    do_wrdi();
    check("R2 wrdi clears", status_o, 8'h00);
    do_wren();
    @(negedge clk_i); wren_i = 1; wrdi_i = 1; step();
    check("R2 wrdi wins", status_o, 8'h00);
  endtask

  task automatic t_map();
    logic [14:0] pts [8] = '{15'h0000, 15'h1FFF, 15'h2000, 15'h3FFF,
                             15'h4000, 15'h5FFF, 15'h6000, 15'h7FFF};
    for (int l = 0; l < 4; l++) begin
      set_sr({4'h0, 2'(l), 2'b00});
      check("R3 level readback", status_o, {4'h0, 2'(l), 2'b00});
      do_wren();
      for (int i = 0; i < 8; i++) begin
        addr_i = pts[i]; #1;
        check($sformatf("R3 lvl%0d addr %h", l, pts[i]), {7'd0, arr_wr_ok_o},
              {7'd0, ~exp_prot(2'(l), pts[i])});
      end
      do_wrdi();
    end
    set_sr(8'h00);
  endtask

  task automatic t_nowel();
    wp_i = 0; addr_i = 15'h0010; #1;
    check("R5 no wel arr", {7'd0, arr_wr_ok_o}, 8'h00);
    check("R5 no wel sr", {7'd0, sr_wr_ok_o}, 8'h00);
    wp_i = 1; #1;
    check("R5 no wel arr wp high", {7'd0, arr_wr_ok_o}, 8'h00);
  endtask

  task automatic t_hw();
    set_sr(8'h80);
    check("R6 enable bit loaded", status_o, 8'h80);
    do_wren();
    wp_i = 0; addr_i = 15'h0123; #1;
    check("R4 pin gate sr", {7'd0, sr_wr_ok_o}, 8'h00);
    check("R4 pin gate arr", {7'd0, arr_wr_ok_o}, 8'h01);
    wp_i = 1; #1;
    check("R4 pin high sr", {7'd0, sr_wr_ok_o}, 8'h01);
  endtask

  task automatic t_lock();
    wp_i = 0;
    do_wrsr(8'h0C);
    check("R7 lock keeps enable", status_o, 8'h82);
    check("R6 refused wrsr no busy", {7'd0, status_o[0]}, 8'h00);
    wp_i = 1;
    do_wrsr(8'h00);
    check("R6 accepted wrsr busy", status_o, 8'h03);
    do_done();
    check("R9 done clears", status_o, 8'h00);
  endtask

  task automatic t_busy();
    do_wren();
    do_arr(15'h0100);
    check("R8 arr commit busy", status_o, 8'h03);
    check("R8 busy arr_ok", {7'd0, arr_wr_ok_o}, 8'h00);
    check("R8 busy sr_ok", {7'd0, sr_wr_ok_o}, 8'h00);
    do_wrdi();
    check("R8 wrdi ignored", status_o, 8'h03);
    do_wrsr(8'h8C);
    check("R8 wrsr ignored", status_o, 8'h03);
    do_done();
    check("R9 done clears wel", status_o, 8'h00);
    do_wren();
    check("R8 wren after busy", status_o, 8'h02);
    do_wrdi();
  endtask

  task automatic t_refused_arr();
    set_sr(8'h0C);
    do_wren();
    do_arr(15'h0000);
    check("R10 refused commit", status_o, 8'h0E);
    do_wrdi();
    set_sr(8'h04);
    do_wren();
    do_arr(15'h6000);
    check("R10 refused top quarter", status_o, 8'h06);
    do_arr(15'h5FFF);
    check("R8 allowed below quarter", status_o, 8'h07);
    do_done();
  endtask

  task automatic t_unused();
    set_sr(8'h73);
    check("R11 ignored data bits", status_o, 8'h00);
    set_sr(8'hFF);
    check("R11 unused zero", status_o, 8'h8C);
    set_sr(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    t_reset();
    t_wel();
    t_map();
    t_nowel();
    t_hw();
    t_lock();
    t_busy();
    t_refused_arr();
    t_unused();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule